// File: doc/BRIEF.md
# RTC alarm match and interrupt status

This block sits beside a calendar counter and turns its time of day into interrupts. Software loads six BCD alarm fields (seconds, minutes, hours, day, month, year). When the running calendar equals all six fields, the block latches an alarm flag. A second source of events is the calendar's own carry strobes. When a period is selected, the rollover of seconds, minutes, hours or days latches a periodic flag.

All flags sit in one status register. Software clears a flag by writing a one to its bit. A single level-high interrupt line is active while any latched flag has its enable set. The calendar counter and the bus bridge are outside the block. The calendar arrives as BCD inputs plus a four-bit carry vector. The bus appears as a simple write strobe with an address and data, and a combinational read port.

Register offsets: 0 to 5 hold the alarm fields in the order seconds, minutes, hours, day, month, year. Offset 6 is the interrupt enable. Offset 7 is the periodic select. Offset 8 is the status register.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, every register at offsets 0 to 8 reads 0 and `irq` is low.
- R2: The alarm fields are stored at offsets 0 (seconds), 1 (minutes), 2 (hours), 3 (day), 4 (month) and 5 (year). Each field keeps only its low bits, read back as written: 7, 7, 6, 6, 5 and 8 bits respectively.
- R3: Status bit 6 (offset 8) is set on the clock edge after all six calendar inputs first become equal to the alarm fields. Equality that persists after the flag is cleared does not set the flag again.
- R4: The alarm flag stays set until a status write carries a 1 in bit 6.
- R5: Bit 3 of offset 6 enables the alarm interrupt; no other bit of offset 6 is stored. `irq` is high while the alarm flag is set and bit 3 is 1. Clearing bit 3 drops `irq` but leaves the flag set.
- R6: Bits 0, 1, 2 and 3 of offset 7 select the every-second, every-minute, every-hour and every-day period. A strobe on `cal_carry[k]` sets status bit 2+k on the next edge only when select bit k is 1. `irq` is high while status bit 2+k and select bit k are both 1.
- R7: A status write clears exactly the bits written as 1: 0xFE clears every flag at once, and bits written as 0 keep their flags.
- R8: When a set event and a clearing write of the same status bit fall in the same cycle, the bit ends up set.
- R9: The alarm flag is not set if any single one of the six fields differs from the calendar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read offset |
| rd_data | output | 8 | Combinational read data |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD |
| cal_day | input | 6 | Calendar day of month, BCD |
| cal_mon | input | 5 | Calendar month, BCD |
| cal_year | input | 8 | Calendar year, BCD |
| cal_carry | input | 4 | Rollover strobes: bit 0 second, 1 minute, 2 hour, 3 day |
| irq | output | 1 | Level-high interrupt |

## Verification
The hardest case to reach is a set event and a clearing write landing on the same edge. The bench handles it by moving the calendar into equality on the same falling edge that raises a status write of 0x40. Both then take effect at the next rising edge.

The single-shot rule needs the calendar to stay equal after a clear. To exercise it, the bench holds the matching time for several cycles and then observes the status register. Each of the six fields is walked through an off-by-one mismatch followed by an exact match. The periodic select is swept over all sixteen values against every carry strobe.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_pkg;
  localparam int NFIELD       = 6;
  localparam int NPER         = 4;
  localparam int DW           = 8;
  localparam int OFF_INTEN    = 6;
  localparam int OFF_PSEL     = 7;
  localparam int OFF_STAT     = 8;
  localparam int ALM_EN_BIT   = 3;
  localparam int STAT_ALM_BIT = 6;
  localparam int STAT_PER_LSB = 2;

  typedef logic [NFIELD-1:0][DW-1:0] fields_t;

  // Valid BCD bits of each alarm/calendar field, index 0 = seconds.
  function automatic logic [DW-1:0] field_mask(input int idx);
    case (idx)
      0, 1:    field_mask = 8'h7F;
      2, 3:    field_mask = 8'h3F;
      4:       field_mask = 8'h1F;
      default: field_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic fields_equal(input fields_t a, input fields_t b);
    logic eq;
    eq = 1'b1;
    for (int i = 0; i < NFIELD; i++)
      if ((a[i] & field_mask(i)) != (b[i] & field_mask(i))) eq = 1'b0;
    return eq;
  endfunction

  // Status bits that hold a flag; all others read 0.
  function automatic logic [DW-1:0] live_status_bits();
    logic [DW-1:0] m;
    m = '0;
    m[STAT_ALM_BIT] = 1'b1;
    for (int k = 0; k < NPER; k++) m[STAT_PER_LSB+k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
`timescale 1ns/1ps
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DW-1:0]        wr_data,
  output fields_t              alm_fields,
  output logic                 alm_en,
  output logic [NPER-1:0]      per_sel
);
  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)
        alm_fields[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))
        alm_fields[g] <= wr_data & field_mask(g);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_en  <= 1'b0;
      per_sel <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(OFF_INTEN)) alm_en  <= wr_data[ALM_EN_BIT];
      if (wr_addr == ADDR_W'(OFF_PSEL))  per_sel <= wr_data[NPER-1:0];
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  fields_t alm_fields,
  input  fields_t cal_fields,
  output logic    match,
  output logic    alarm_evt
);
  logic match_q;

  assign match = fields_equal(alm_fields, cal_fields);

  // Reset to 1 so a reset-time equality is not taken as a fresh entry.
  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b1;
    else        match_q <= match;
  end

  assign alarm_evt = match & ~match_q;
endmodule

// File: rtl/rtc_alarm_status.sv
`timescale 1ns/1ps
module rtc_alarm_status
  import rtc_alarm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alarm_evt,
  input  logic [NPER-1:0] per_hit,
  input  logic [DW-1:0]   clr_mask,
  output logic [DW-1:0]   status_q
);
  localparam logic [DW-1:0] LIVE = live_status_bits();
  logic [DW-1:0] status_d;

  always_comb begin
    status_d = status_q & ~clr_mask & LIVE;
    if (alarm_evt) status_d[STAT_ALM_BIT] = 1'b1;
    for (int k = 0; k < NPER; k++)
      if (per_hit[k]) status_d[STAT_PER_LSB+k] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
`timescale 1ns/1ps
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [6:0]        cal_sec,
  input  logic [6:0]        cal_min,
  input  logic [5:0]        cal_hour,
  input  logic [5:0]        cal_day,
  input  logic [4:0]        cal_mon,
  input  logic [7:0]        cal_year,
  input  logic [3:0]        cal_carry,
  output logic              irq
);
  fields_t         alm_fields;
  fields_t         cal_fields;
  logic            alm_en;
  logic [NPER-1:0] per_sel;
  logic [NPER-1:0] per_hit;
  logic            match;
  logic            alarm_evt;
  logic [DW-1:0]   clr_mask;
  logic [DW-1:0]   status_q;
  logic            alm_irq;
  logic            per_irq;

  assign cal_fields = {cal_year, 3'b000, cal_mon, 2'b00, cal_day,
                       2'b00, cal_hour, 1'b0, cal_min, 1'b0, cal_sec};

  rtc_alarm_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .alm_fields(alm_fields), .alm_en(alm_en),
    .per_sel(per_sel)
  );

  rtc_alarm_match match_i (
    .clk(clk), .rst_n(rst_n), .alm_fields(alm_fields),
    .cal_fields(cal_fields), .match(match), .alarm_evt(alarm_evt)
  );

  assign per_hit  = cal_carry & per_sel;
  assign clr_mask = (wr_en && wr_addr == ADDR_W'(OFF_STAT)) ? wr_data : '0;

  rtc_alarm_status status_i (
    .clk(clk), .rst_n(rst_n), .alarm_evt(alarm_evt), .per_hit(per_hit),
    .clr_mask(clr_mask), .status_q(status_q)
  );

  assign alm_irq = status_q[STAT_ALM_BIT] & alm_en;
  assign per_irq = |(status_q[STAT_PER_LSB +: NPER] & per_sel);
  assign irq     = alm_irq | per_irq;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NFIELD; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = alm_fields[i];
    if (rd_addr == ADDR_W'(OFF_INTEN)) rd_data[ALM_EN_BIT] = alm_en;
    if (rd_addr == ADDR_W'(OFF_PSEL))  rd_data[NPER-1:0]   = per_sel;
    if (rd_addr == ADDR_W'(OFF_STAT))  rd_data             = status_q;
  end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
`timescale 1ns/1ps
module rtc_alarm_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alarm_evt,
  input logic [7:0] clr_mask,
  input logic [7:0] status_q,
  input logic       alm_en,
  input logic [3:0] per_sel,
  input logic [3:0] per_hit,
  input logic [3:0] cal_carry,
  input logic       irq
);
  // R3: an entry into equality is a one-cycle event
  a_r3_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> !alarm_evt);

  // R4: the alarm flag holds unless bit 6 is written with 1
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[6] && !clr_mask[6]) |=> status_q[6]);

  // R5: with every enable off, no interrupt
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!alm_en && per_sel == 4'd0) |-> !irq);

  // R5: interrupt only with a flag present
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 8'd0) |-> !irq);

  // R6: a selected second strobe latches its flag
  a_r6_sec_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_carry[0] && per_sel[0]) |=> status_q[2]);

  // R6: an unselected day strobe on a clear flag leaves it clear
  a_r6_day_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_carry[3] && !per_sel[3] && !status_q[5]) |=> !status_q[5]);

  // R7: no clear and no event keeps status unchanged
  a_r7_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == 8'd0 && !alarm_evt && per_hit == 4'd0) |=> $stable(status_q));

  // R8: a set event wins over a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> status_q[6]);
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .alarm_evt(alarm_evt), .clr_mask(clr_mask),
  .status_q(status_q), .alm_en(alm_en), .per_sel(per_sel),
  .per_hit(per_hit), .cal_carry(cal_carry), .irq(irq)
);

// File: tb/rtc_alarm_irq_tb_top.sv
`timescale 1ns/1ps
module rtc_alarm_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [5:0][7:0] cal;
  logic [3:0] cal_carry = '0;
  logic       irq;
  int         n_vec = 0;
  int         n_bad = 0;
  logic [5:0][7:0] tgt;
  logic [7:0] mk [6];

  always #5 clk = ~clk;

  rtc_alarm_irq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cal_sec(cal[0][6:0]), .cal_min(cal[1][6:0]), .cal_hour(cal[2][5:0]),
    .cal_day(cal[3][5:0]), .cal_mon(cal[4][4:0]), .cal_year(cal[5]),
    .cal_carry(cal_carry), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input logic [3:0] c);
    @(negedge clk);
    cal_carry = c;
    @(negedge clk);
    cal_carry = '0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 6; i++) cal[i] = 8'h01;
    mk[0] = 8'h7F; mk[1] = 8'h7F; mk[2] = 8'h3F;
    mk[3] = 8'h3F; mk[4] = 8'h1F; mk[5] = 8'hFF;
    tgt[0] = 8'h45; tgt[1] = 8'h30; tgt[2] = 8'h12;
    tgt[3] = 8'h15; tgt[4] = 8'h06; tgt[5] = 8'h24;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1: reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      check("R1 reset reg", v, 8'h00);
    end
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2: field widths and order
    for (int a = 0; a < 6; a++) wr(4'(a), 8'hFF);
    for (int a = 0; a < 6; a++) begin
      rd(4'(a), v);
      check("R2 field mask", v, mk[a]);
    end
    for (int a = 0; a < 6; a++) wr(4'(a), tgt[a]);
    for (int a = 0; a < 6; a++) begin
      rd(4'(a), v);
      check("R2 field readback", v, tgt[a]);
    end

    // R9 / R3: each field off by one, then exact match
    for (int f = 0; f < 6; f++) begin
      @(negedge clk);
      for (int i = 0; i < 6; i++) cal[i] = tgt[i];
      cal[f] = tgt[f] ^ 8'h01;
      step();
      rd(4'd8, v);
      check("R9 single field mismatch", v, 8'h00);
      @(negedge clk);
      cal[f] = tgt[f];
      @(negedge clk);
      rd(4'd8, v);
      check("R3 alarm on match", v, 8'h40);
      step(); step();
      rd(4'd8, v);
      check("R4 flag holds", v, 8'h40);
      wr(4'd8, 8'h40);
      rd(4'd8, v);
      check("R4 cleared by one", v, 8'h00);
    end

    // R3: equality persists after clear, no re-fire
    repeat (4) step();
    rd(4'd8, v);
    check("R3 no retrigger", v, 8'h00);

    // R8: event and clear on the same edge
    @(negedge clk);
    cal[0] = tgt[0] ^ 8'h01;
    @(negedge clk);
    cal[0] = tgt[0];
    wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h40;
    @(negedge clk);
    wr_en = 1'b0;
    rd(4'd8, v);
    check("R8 set wins", v, 8'h40);

    // R5: interrupt enable gating
    check("R5 irq off without enable", {7'd0, irq}, 8'h00);
    wr(4'd6, 8'h08);
    check("R5 irq on", {7'd0, irq}, 8'h01);
    rd(4'd6, v);
    check("R5 enable readback", v, 8'h08);
    wr(4'd6, 8'hF7);
    check("R5 other bits ignored irq", {7'd0, irq}, 8'h00);
    rd(4'd6, v);
    check("R5 other bits not stored", v, 8'h00);
    rd(4'd8, v);
    check("R5 flag kept when disabled", v, 8'h40);

    // R7: partial clears and clear-all
    wr(4'd7, 8'h0F);
    pulse(4'hF);
    rd(4'd8, v);
    check("R7 all flags set", v, 8'h7C);
    wr(4'd8, 8'h00);
    rd(4'd8, v);
    check("R7 write zero no effect", v, 8'h7C);
    wr(4'd8, 8'hBF);
    rd(4'd8, v);
    check("R7 keep bit 6", v, 8'h40);
    pulse(4'hF);
    wr(4'd8, 8'hFE);
    rd(4'd8, v);
    check("R7 FE clears all", v, 8'h00);

    // R6: sweep every select value against every strobe
    for (int s = 0; s < 16; s++) begin
      wr(4'd7, 8'(s));
      for (int k = 0; k < 4; k++) begin
        pulse(4'(1 << k));
        rd(4'd8, v);
        check("R6 periodic flag", v, s[k] ? 8'(1 << (k + 2)) : 8'h00);
        check("R6 periodic irq", {7'd0, irq}, {7'd0, s[k]});
        wr(4'd8, 8'hFE);
      end
    end

    finish_run();
  end
endmodule